// File: doc/BRIEF.md
# Dual-Sample Serial Frame Receiver

This block sits on the slave side of an SPI link from a microcontroller. The master drives SCK in mode 0 and also drives a separate load strobe. The load strobe is high while a 32-bit frame is being clocked in, and it falls when the frame is complete. Each frame holds two 16-bit words, sent most significant bit first. The first word belongs to player 1 and the second to player 2. Only the low 12 bits of each word carry sample data; the top bits are padding.

All four incoming wires are brought into the system clock domain through flip-flop synchronisers. SCK edges are found by comparing successive synchronised values, so the system clock must run at least four times faster than SCK. When load falls after exactly 32 counted bits, both samples appear on the outputs together with a one-cycle valid pulse. A frame with any other bit count is dropped, and the previous samples stay on the outputs. The data-out wire back to the master carries no information and is held at zero.

Top module: `spi_dual_sample_rx`

## Requirements
- R1: While rst_ni is low and after its release, p1_o and p2_o read 0 and valid_o reads 0 until the first accepted frame.
- R2: A frame is received MSB first. Bit 31, the first bit sent, is the MSB. Bits 31..16 form the player 1 word and bits 15..0 form the player 2 word. p1_o takes word bits 27..16 and p2_o takes word bits 11..0.
- R3: The top 4 bits of each 16-bit word (frame bits 31..28 and 15..12) have no effect on p1_o or p2_o.
- R4: valid_o goes high for exactly one clock after load_i falls at the end of a 32-bit frame. p1_o and p2_o change only in that cycle.
- R5: A frame that ends with fewer or more than 32 counted SCK rising edges produces no valid_o pulse, and p1_o and p2_o keep their previous values.
- R6: A rising edge of load_i discards any bits already counted, so a complete frame that follows an aborted partial frame is received correctly.
- R7: SCK rising edges are not counted while cs_ni is high or load_i is low.
- R8: miso_o is held at 0 at all times.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock, at least 4x the SCK rate |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sck_i | input | 1 | Serial clock from the master (mode 0) |
| mosi_i | input | 1 | Serial data from the master |
| cs_ni | input | 1 | Chip select, active low |
| load_i | input | 1 | Frame strobe: high while a frame is shifted in |
| miso_o | output | 1 | Serial data to the master, constant 0 |
| p1_o | output | SAMPLE_W | Player 1 sample |
| p2_o | output | SAMPLE_W | Player 2 sample |
| valid_o | output | 1 | One-cycle pulse when new samples are presented |

## Verification
The bench uses the default parameters: SAMPLE_W=12, WORD_W=16 and SYNC_STAGES=2. With these values the frame is the full 32-bit layout, including the 4-bit padding in each word. Patterns with nonzero padding can therefore show that the padding is dropped. Frames of 31 and 33 bits sit one bit either side of the accepted length and test the discard rule. SCK is driven at one eighth of the system clock, which keeps every edge visible through the two-stage synchroniser.

// File: rtl/spi_dual_rx_pkg.sv
package spi_dual_rx_pkg;
  localparam int unsigned NUM_WORDS = 2;

  typedef struct packed {
    logic cs_n;
    logic load;
    logic mosi;
    logic sck;
  } rx_pins_t;
endpackage

// File: rtl/rx_sync.sv
module rx_sync #(
  parameter int unsigned WIDTH   = 1,
  parameter int unsigned STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] stg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg_q[0] <= RST_VAL;
    else         stg_q[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[s] <= RST_VAL;
      else         stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/rx_shifter.sv
module rx_shifter #(
  parameter int unsigned STORE_BITS = 28,
  parameter int unsigned FRAME_BITS = 32,
  localparam int unsigned CNT_MAX = FRAME_BITS + 1,
  localparam int unsigned CNT_W   = $clog2(CNT_MAX + 1)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  clear_i,
  input  logic                  shift_en_i,
  input  logic                  bit_i,
  output logic [STORE_BITS-1:0] data_o,
  output logic [CNT_W-1:0]      cnt_o
);
  logic [STORE_BITS-1:0] sr_q;
  logic [CNT_W-1:0]      cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q  <= '0;
      cnt_q <= '0;
    end else if (clear_i) begin
      sr_q  <= '0;
      cnt_q <= '0;
    end else if (shift_en_i) begin
      // leading pad bits fall off the top and are never stored
      sr_q <= {sr_q[STORE_BITS-2:0], bit_i};
      if (cnt_q != CNT_W'(CNT_MAX)) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign data_o = sr_q;
  assign cnt_o  = cnt_q;
endmodule

// File: rtl/rx_unpack.sv
module rx_unpack #(
  parameter int unsigned SAMPLE_W  = 12,
  parameter int unsigned WORD_W    = 16,
  parameter int unsigned NUM_WORDS = 2,
  localparam int unsigned STORE_BITS = NUM_WORDS * WORD_W - (WORD_W - SAMPLE_W)
) (
  input  logic                               clk_i,
  input  logic                               rst_ni,
  input  logic                               commit_i,
  input  logic [STORE_BITS-1:0]              data_i,
  output logic [NUM_WORDS-1:0][SAMPLE_W-1:0] sample_o,
  output logic                               valid_o
);
  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    // word 0 is sent first and so lands highest
    localparam int unsigned LSB = (NUM_WORDS - 1 - w) * WORD_W;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       sample_o[w] <= '0;
      else if (commit_i) sample_o[w] <= data_i[LSB +: SAMPLE_W];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) valid_o <= 1'b0;
    else         valid_o <= commit_i;
  end
endmodule

// File: rtl/spi_dual_sample_rx.sv
module spi_dual_sample_rx
  import spi_dual_rx_pkg::*;
#(
  parameter int unsigned SAMPLE_W    = 12,
  parameter int unsigned WORD_W      = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                sck_i,
  input  logic                mosi_i,
  input  logic                cs_ni,
  input  logic                load_i,
  output logic                miso_o,
  output logic [SAMPLE_W-1:0] p1_o,
  output logic [SAMPLE_W-1:0] p2_o,
  output logic                valid_o
);
  localparam int unsigned FRAME_BITS = NUM_WORDS * WORD_W;
  localparam int unsigned STORE_BITS = FRAME_BITS - (WORD_W - SAMPLE_W);
  localparam int unsigned CNT_W      = $clog2(FRAME_BITS + 2);

  rx_pins_t pins_raw, pins_s;
  logic     sck_q, load_q;
  logic     sck_rise, load_rise, load_fall;
  logic     shift_en, commit;
  logic [STORE_BITS-1:0]              sr_data;
  logic [CNT_W-1:0]                   bit_cnt;
  logic [NUM_WORDS-1:0][SAMPLE_W-1:0] samples;

  assign pins_raw = '{cs_n: cs_ni, load: load_i, mosi: mosi_i, sck: sck_i};

  rx_sync #(
    .WIDTH  ($bits(rx_pins_t)),
    .STAGES (SYNC_STAGES),
    .RST_VAL(4'b1000)
  ) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pins_raw),
    .q_o   (pins_s)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_q  <= 1'b0;
      load_q <= 1'b0;
    end else begin
      sck_q  <= pins_s.sck;
      load_q <= pins_s.load;
    end
  end

  assign sck_rise  = pins_s.sck & ~sck_q;
  assign load_rise = pins_s.load & ~load_q;
  assign load_fall = ~pins_s.load & load_q;
  assign shift_en  = sck_rise & pins_s.load & ~pins_s.cs_n;
  assign commit    = load_fall && (bit_cnt == CNT_W'(FRAME_BITS));

  rx_shifter #(
    .STORE_BITS(STORE_BITS),
    .FRAME_BITS(FRAME_BITS)
  ) u_shift (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clear_i   (load_rise),
    .shift_en_i(shift_en),
    .bit_i     (pins_s.mosi),
    .data_o    (sr_data),
    .cnt_o     (bit_cnt)
  );

  rx_unpack #(
    .SAMPLE_W (SAMPLE_W),
    .WORD_W   (WORD_W),
    .NUM_WORDS(NUM_WORDS)
  ) u_unpack (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .commit_i(commit),
    .data_i  (sr_data),
    .sample_o(samples),
    .valid_o (valid_o)
  );

  assign p1_o   = samples[0];
  assign p2_o   = samples[1];
  assign miso_o = 1'b0;
endmodule

// File: rtl/spi_dual_rx_chk.sv
module spi_dual_rx_chk #(
  parameter int unsigned SAMPLE_W = 12,
  parameter int unsigned CNT_W    = 6,
  parameter int unsigned CNT_MAX  = 33
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                valid_o,
  input logic                miso_o,
  input logic [SAMPLE_W-1:0] p1_o,
  input logic [SAMPLE_W-1:0] p2_o,
  input logic                load_fall,
  input logic [CNT_W-1:0]    bit_cnt
);
  // R4
  valid_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);

  // R4
  valid_after_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $past(load_fall));

  // R5
  hold_outputs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> ($stable(p1_o) && $stable(p2_o)));

  // R5
  cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_cnt <= CNT_W'(CNT_MAX));

  // R8
  miso_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    miso_o == 1'b0);
endmodule

bind spi_dual_sample_rx spi_dual_rx_chk #(
  .SAMPLE_W(SAMPLE_W),
  .CNT_W   (CNT_W),
  .CNT_MAX (FRAME_BITS + 1)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .valid_o  (valid_o),
  .miso_o   (miso_o),
  .p1_o     (p1_o),
  .p2_o     (p2_o),
  .load_fall(load_fall),
  .bit_cnt  (bit_cnt)
);

// File: tb/spi_dual_sample_rx_tb.sv
`timescale 1ns/1ps
module spi_dual_sample_rx_tb;
  localparam int SW = 12;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic sck = 1'b0, mosi = 1'b0, cs_n = 1'b1, load = 1'b0;
  logic miso, valid;
  logic [SW-1:0] p1, p2;
  logic [2*SW-1:0] exp_q[$];
  logic [SW-1:0] last_p1 = '0, last_p2 = '0;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  spi_dual_sample_rx u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .sck_i(sck), .mosi_i(mosi),
    .cs_ni(cs_n), .load_i(load), .miso_o(miso),
    .p1_o(p1), .p2_o(p2), .valid_o(valid)
  );

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic clks(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic pulse_sck(input int n);
    for (int i = 0; i < n; i++) begin
      clks(4); sck = 1'b1; clks(4); sck = 1'b0;
    end
  endtask

  // driver: sends nbits of data MSB first; pushes expectation when nbits==32
  task automatic send(input logic [31:0] data, input int nbits);
    cs_n = 1'b0; clks(4);
    load = 1'b1; clks(4);
    for (int i = 0; i < nbits; i++) begin
      mosi = (i < 32) ? data[31-i] : 1'b1;
      clks(4); sck = 1'b1; clks(4); sck = 1'b0;
    end
    clks(4);
    if (nbits == 32) exp_q.push_back({data[27:16], data[11:0]});
    load = 1'b0; clks(12);
    cs_n = 1'b1; clks(4);
  endtask

  task automatic drained(input string req);
    chk(exp_q.size() == 0, req, exp_q.size(), 0);
  endtask

  task automatic held(input string req);
    chk({p1, p2} == {last_p1, last_p2}, req, {8'h0, p1, p2}, {8'h0, last_p1, last_p2});
  endtask

  // monitor: pops and compares on every valid pulse
  always @(negedge clk) begin
    if (rst_ni && valid) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R5 unexpected valid", {8'h0, p1, p2}, 0);
      end else begin
        logic [2*SW-1:0] e;
        e = exp_q.pop_front();
        chk({p1, p2} == e, "R2/R4 sample data", {8'h0, p1, p2}, {8'h0, e});
        last_p1 = p1; last_p2 = p2;
      end
      chk(miso == 1'b0, "R8 miso", miso, 0);
    end
  end

  initial begin
    clks(100000);
    if (!done) begin
      chk(1'b0, "watchdog", 0, 1);
      summary();
    end
  end

  initial begin
    clks(3);
    @(negedge clk);
    chk(p1 == '0 && p2 == '0, "R1 reset samples", {p1, p2}, 0);
    chk(valid == 1'b0, "R1 reset valid", valid, 0);
    rst_ni = 1'b1;
    clks(5); @(negedge clk);
    chk(p1 == '0 && p2 == '0 && valid == 1'b0, "R1 after release", {p1, p2, valid}, 0);
    chk(miso == 1'b0, "R8 idle miso", miso, 0);

    // R2 basic frame
    send(32'h0ABC_0123, 32); drained("R2 frame 1");
    send(32'h0FFF_0000, 32); drained("R2 frame 2");
    // R3 nonzero padding ignored
    send(32'hF555_9AAA, 32); drained("R3 padding");
    chk(p1 == 12'h555 && p2 == 12'hAAA, "R3 padded values", {p1, p2}, 24'h555AAA);

    // R5 short and long frames discarded
    send(32'h0111_0222, 31); drained("R5 short");  held("R5 short held");
    send(32'h0333_0444, 33); drained("R5 long");   held("R5 long held");
    send(32'h0555_0666, 0);  drained("R5 empty");  held("R5 empty held");

    // R6 aborted partial frame followed by full frame
    send(32'h0777_0888, 20);
    send(32'h0246_0135, 32); drained("R6 after partial");

    // R7 edges with load low are ignored
    cs_n = 1'b0; pulse_sck(8); cs_n = 1'b1; clks(12);
    held("R7 load low");
    // R7 edges with cs high inside load are not counted
    load = 1'b1; clks(4); pulse_sck(5);
    cs_n = 1'b0; clks(4);
    for (int i = 0; i < 32; i++) begin
      mosi = logic'((32'h0C3A_05A5 >> (31 - i)) & 1);
      clks(4); sck = 1'b1; clks(4); sck = 1'b0;
    end
    clks(4);
    exp_q.push_back({12'hC3A, 12'h5A5});
    load = 1'b0; clks(12); cs_n = 1'b1; clks(4);
    drained("R7 cs high");

    // R4 back-to-back frames each give one pulse
    send(32'h0001_0FFE, 32);
    send(32'h0800_0400, 32); drained("R4 back to back");

    clks(10);
    done = 1;
    summary();
  end
endmodule